// File: doc/BRIEF.md
# Crystal-Clocked Overflow Timer with Time-of-Day Counters

This block is a 16-bit up-counter whose count input is a slow watch-crystal clock (nominally 32.768 kHz). That input is not related to the system clock. The input passes through a synchroniser and an edge detector into the system domain. A count happens on a rising edge of the input only when the counter has been armed by an earlier falling edge. Any write to a counter byte removes that arming. So a write that lands after the input has already gone low costs one count, and software that must not lose time has to finish its write while the input is still high.

When the counter wraps past its all-ones value it raises an interrupt flag. An optional reload then sets the most significant counter bit, which gives the next wrap exactly 32768 crystal periods (one second) later. Each wrap also steps a set of seconds, minutes and hours registers. All three update in the same system cycle, so a read never sees half of a carry.

A simple system-clock register port gives access to the counter bytes, the control bits, the flag and the time registers. Reads are combinational on the read address.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset the register map reads as follows: address 0 (counter bits 7:0) = 0, address 1 (counter bits 15:8) = 0, address 2 (control: bit0 run, bit1 interrupt enable, bit2 reload) = 0, address 3 (status: bit0 flag, bit1 armed) = 0, address 4 seconds = 0, address 5 minutes = 0, address 6 hours = 12, address 7 = 0, and `irq` = 0.
- R2: The status armed bit (address 3 bit1) sets when a falling edge of `xtal_in` is detected. While run is 1, each detected rising edge with armed set adds one to the counter. A rising edge with armed clear is not counted.
- R3: A write to address 0 or 1 clears armed. A rising edge after such a write is counted only if a falling edge was detected after the write.
- R4: An increment from 0xFFFF sets the status flag. The counter becomes 0x0000 if the reload bit (address 2 bit2) is 0, and 0x8000 if it is 1.
- R5: `irq` is high exactly when the flag and the interrupt enable (address 2 bit1) are both 1. Writing address 3 with bit0 = 1 clears the flag, but a wrap in the same cycle keeps the flag set.
- R6: Each counter wrap advances the seconds. Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. Hours wrap from 23 to 0.
- R7: Writing address 4, 5 or 6 loads seconds, minutes or hours. The time registers can be read at any time, and between wraps they hold their value.
- R8: While run is 0, detected rising edges leave the counter unchanged, but falling edges still set armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_in | input | 1 | Crystal count input, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| irq | output | 1 | Wrap interrupt request |

## Verification
The bench aims at the lost-count rule. It writes the counter while the input is low and again while it is high, and checks that only the first case drops a count. A design that armed on a level, or that did not disarm on a write, would count the edge that must be lost. The bench times a flag clear into the exact cycle of a wrap, where a design that let the clear win would lose an interrupt. A long sweep of forced wraps passes through the minute, hour and midnight boundaries and compares every reading with arithmetic on total seconds, which exposes any off-by-one in a wrap limit or any missing carry.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  localparam logic [2:0] A_CNT_LO = 3'd0;
  localparam logic [2:0] A_CNT_HI = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_STAT   = 3'd3;
  localparam logic [2:0] A_SEC    = 3'd4;
  localparam logic [2:0] A_MIN    = 3'd5;
  localparam logic [2:0] A_HOUR   = 3'd6;

  localparam logic [7:0] SEC_LAST  = 8'd59;
  localparam logic [7:0] MIN_LAST  = 8'd59;
  localparam logic [7:0] HOUR_LAST = 8'd23;

  typedef struct packed {
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  // One-second step with carries; at or past the limit a field wraps to zero.
  function automatic rtc_time_t time_step(rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec >= SEC_LAST) begin
      n.sec = 8'd0;
      if (t.min >= MIN_LAST) begin
        n.min = 8'd0;
        n.hour = (t.hour >= HOUR_LAST) ? 8'd0 : t.hour + 8'd1;
      end else begin
        n.min = t.min + 8'd1;
      end
    end else begin
      n.sec = t.sec + 8'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_sync_edge.sv
module rtc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain;
  logic         last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[MSB-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[MSB];
  end

  assign rise = chain[MSB] & ~last;
  assign fall = ~chain[MSB] & last;
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rise,
  input  logic                    fall,
  input  logic                    run,
  input  logic                    reload,
  input  logic [CNT_W/DATA_W-1:0] byte_we,
  input  logic [DATA_W-1:0]       wdata,
  output logic [CNT_W-1:0]        count,
  output logic                    armed,
  output logic                    inc_evt,
  output logic                    ovf_evt,
  output logic                    cnt_wr
);
  localparam int NB = CNT_W / DATA_W;

  // Returns {wrapped, next value}; on a wrap the reload sets only the top bit.
  function automatic logic [CNT_W:0] count_advance(logic [CNT_W-1:0] cur, logic rl);
    logic [CNT_W:0] sum;
    sum = {1'b0, cur} + {{CNT_W{1'b0}}, 1'b1};
    if (sum[CNT_W] && rl) sum[CNT_W-1] = 1'b1;
    return sum;
  endfunction

  logic [CNT_W:0]   adv;
  logic [CNT_W-1:0] count_d;

  assign cnt_wr  = |byte_we;
  assign inc_evt = rise & armed & run & ~cnt_wr;
  assign adv     = count_advance(count, reload);
  assign ovf_evt = inc_evt & adv[CNT_W];

  always_comb begin
    count_d = count;
    if (inc_evt) count_d = adv[CNT_W-1:0];
    for (int b = 0; b < NB; b++) begin
      if (byte_we[b]) count_d[b*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else begin
      count <= count_d;
      if (cnt_wr)    armed <= 1'b0;
      else if (fall) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_tick_pkg::*;
#(
  parameter logic [7:0] HOUR_INIT = 8'd12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [2:0] we,
  input  logic [7:0] wdata,
  output rtc_time_t  now
);
  rtc_time_t nxt;

  always_comb begin
    nxt = step ? time_step(now) : now;
    if (we[0]) nxt.sec  = wdata;
    if (we[1]) nxt.min  = wdata;
    if (we[2]) nxt.hour = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '{hour: HOUR_INIT, min: 8'd0, sec: 8'd0};
    else        now <= nxt;
  end
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int         CNT_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] HOUR_INIT   = 8'd12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_in,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int DATA_W = 8;
  localparam int NB     = CNT_W / DATA_W;

  logic            rise_evt, fall_evt;
  logic [NB-1:0]   byte_we;
  logic [CNT_W-1:0] count;
  logic            armed, inc_evt, ovf_evt, cnt_wr;
  logic            run, irq_en, reload, flag, flag_clr;
  logic [2:0]      time_wr;
  rtc_time_t       now;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bwe
      assign byte_we[b] = wr_en && (wr_addr == 3'(b));
    end
  endgenerate

  assign flag_clr   = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign time_wr[0] = wr_en && (wr_addr == A_SEC);
  assign time_wr[1] = wr_en && (wr_addr == A_MIN);
  assign time_wr[2] = wr_en && (wr_addr == A_HOUR);

  rtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(xtal_in),
    .rise(rise_evt), .fall(fall_evt)
  );

  rtc_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .fall(fall_evt),
    .run(run), .reload(reload), .byte_we(byte_we), .wdata(wr_data),
    .count(count), .armed(armed), .inc_evt(inc_evt),
    .ovf_evt(ovf_evt), .cnt_wr(cnt_wr)
  );

  rtc_timekeep #(.HOUR_INIT(HOUR_INIT)) u_time (
    .clk(clk), .rst_n(rst_n), .step(ovf_evt), .we(time_wr),
    .wdata(wr_data), .now(now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      irq_en <= 1'b0;
      reload <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        run    <= wr_data[0];
        irq_en <= wr_data[1];
        reload <= wr_data[2];
      end
      if (ovf_evt)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assign irq = flag & irq_en;

  always_comb begin
    rd_data = 8'd0;
    case (rd_addr)
      A_CTRL:  rd_data = {5'd0, reload, irq_en, run};
      A_STAT:  rd_data = {6'd0, armed, flag};
      A_SEC:   rd_data = now.sec;
      A_MIN:   rd_data = now.min;
      A_HOUR:  rd_data = now.hour;
      default: begin
        for (int b = 0; b < NB; b++) begin
          if (rd_addr == 3'(b)) rd_data = count[b*DATA_W +: DATA_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             reload,
  input logic [CNT_W-1:0] count,
  input logic             armed,
  input logic             fall_evt,
  input logic             inc_evt,
  input logic             ovf_evt,
  input logic             cnt_wr,
  input logic             flag,
  input logic             flag_clr,
  input logic [2:0]       time_wr,
  input logic [7:0]       sec,
  input logic [7:0]       min,
  input logic [7:0]       hour
);
  p_inc_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |-> (armed && run));

  p_fall_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !cnt_wr) |=> armed);

  p_write_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !armed);

  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag);

  p_reload_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && reload) |=> (count == {1'b1, {(CNT_W-1){1'b0}}}));

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_evt) |=> !flag);

  p_sec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && time_wr == 3'd0 && sec < 8'd59) |=> (sec == 8'($past(sec) + 8'd1)));

  p_time_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_evt && time_wr == 3'd0) |=> ($stable(sec) && $stable(min) && $stable(hour)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));
endmodule

bind rtc_tick_timer rtc_tick_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .reload(reload), .count(count),
  .armed(armed), .fall_evt(fall_evt), .inc_evt(inc_evt), .ovf_evt(ovf_evt),
  .cnt_wr(cnt_wr), .flag(flag), .flag_clr(flag_clr), .time_wr(time_wr),
  .sec(now.sec), .min(now.min), .hour(now.hour)
);

// File: tb/rtc_tick_timer_bench.sv
module rtc_tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_tick_timer u_rtc_tick_timer (
    .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic set_x(logic v);
    @(negedge clk);
    xtal_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse();
    set_x(1'b0);
    set_x(1'b1);
  endtask

  task automatic check_time(string tag, int tot);
    int s, m, h;
    rd(3'd4, s);
    rd(3'd5, m);
    rd(3'd6, h);
    check({tag, " sec"}, s, tot % 60);
    check({tag, " min"}, m, (tot / 60) % 60);
    check({tag, " hour"}, h, (tot / 3600) % 24);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v, tot, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every address
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 addr %0d", a), v, (a == 6) ? 12 : 0);
    end
    check("R1 irq", int'(irq), 0);

    // R2: rise without an earlier fall is not counted
    wr(3'd2, 8'h01);
    set_x(1'b1);
    rd_cnt(v); check("R2 unarmed rise", v, 0);
    set_x(1'b0);
    rd(3'd3, v); check("R2 armed after fall", v, 2);
    set_x(1'b1);
    rd_cnt(v); check("R2 first count", v, 1);
    for (int i = 2; i <= 21; i++) begin
      pulse();
      rd_cnt(v); check("R2 count sweep", v, i);
    end

    // R8: run off ignores rises, fall still arms
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h05);
    set_x(1'b0);
    rd(3'd3, v); check("R8 armed while stopped", v, 2);
    set_x(1'b1);
    for (int i = 0; i < 4; i++) pulse();
    rd_cnt(v); check("R8 count held", v, 5);

    // R3: write after input low loses the next edge
    wr(3'd2, 8'h01);
    set_x(1'b0);
    wr(3'd0, 8'h10);
    rd(3'd3, v); check("R3 write disarms", v, 0);
    set_x(1'b1);
    rd_cnt(v); check("R3 edge lost", v, 16'h0010);
    pulse();
    rd_cnt(v); check("R3 next edge counted", v, 16'h0011);
    // R3: write while input high keeps the edge
    wr(3'd0, 8'h20);
    pulse();
    rd_cnt(v); check("R3 write before fall counted", v, 16'h0020 + 1);

    // R4/R5: wrap without reload, interrupt enabled
    wr(3'd2, 8'h03);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFE);
    pulse();
    rd_cnt(v); check("R4 FFFF reached", v, 16'hFFFF);
    rd(3'd3, v); check("R5 no flag yet", v & 1, 0);
    pulse();
    rd_cnt(v); check("R4 wrap to zero", v, 0);
    rd(3'd3, v); check("R4 flag set", v & 1, 1);
    check("R5 irq high", int'(irq), 1);
    tot = 12 * 3600 + 1;
    check_time("R6 first tick", tot);

    wr(3'd3, 8'h01);
    rd(3'd3, v); check("R5 flag cleared", v & 1, 0);
    check("R5 irq low", int'(irq), 0);

    // R5: enable off masks irq; R4: reload gives 0x8000
    wr(3'd2, 8'h05);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFF);
    pulse();
    rd_cnt(v); check("R4 reload top bit", v, 16'h8000);
    rd(3'd3, v); check("R5 flag with enable off", v & 1, 1);
    check("R5 irq masked", int'(irq), 0);
    tot = tot + 1;

    // R5: clear in the same cycle as a wrap leaves the flag set
    wr(3'd3, 8'h01);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFF);
    set_x(1'b0);
    @(negedge clk);
    xtal_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd3, v); check("R5 set beats clear", v & 1, 1);
    rd_cnt(v); check("R4 wrap during clear", v, 16'h8000);
    tot = tot + 1;
    check_time("R6 after race", tot);

    // R7: time load and readback
    wr(3'd4, 8'd30); wr(3'd5, 8'd57); wr(3'd6, 8'd23);
    tot = 23 * 3600 + 57 * 60 + 30;
    check_time("R7 load", tot);
    repeat (20) @(negedge clk);
    check_time("R7 hold", tot);

    // R6: sweep of forced wraps across minute, hour and midnight
    wr(3'd2, 8'h01);
    for (int i = 0; i < 200; i++) begin
      wr(3'd0, 8'hFF);
      wr(3'd1, 8'hFF);
      pulse();
      tot = (tot + 1) % 86400;
      check_time($sformatf("R6 sweep %0d", i), tot);
    end
    rd_cnt(c); check("R4 sweep wrap value", c, 0);

    // R6: second sweep across the noon hour
    wr(3'd4, 8'd40); wr(3'd5, 8'd59); wr(3'd6, 8'd11);
    tot = 11 * 3600 + 59 * 60 + 40;
    for (int i = 0; i < 40; i++) begin
      wr(3'd1, 8'hFF);
      wr(3'd0, 8'hFF);
      pulse();
      tot = tot + 1;
      check_time($sformatf("R6 noon %0d", i), tot);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule